// File: doc/BRIEF.md
# Hit Record Stream Framer

This block turns the payload words of one event into a single framed record for a host-facing word stream. Each record starts with a header word and ends with a trailer word. The header carries a type code, the link error byte and the event number. The trailer carries four error flags, the number of payload words and the event number. Two record types exist. Hit records pass their payload words through unchanged. Z records overwrite the top six bits of every payload word with a fixed tag and the source id.

The upstream source presents words on a valid/ready input. An event begins when the first word or the end-of-event strobe is offered. An event ends on the end-of-event strobe, which may arrive together with the last payload word or on its own. The output is a 32-bit valid/ready stream fed by a single output register. Backpressure on the output stalls the input through `in_ready`.

For hit records, the top six bits of each payload word are a track number, and valid track numbers start at 1. A track number of zero raises an error status output that stays set until the next record starts.

Top module: `hit_record_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `in_ready` and `trk_err` are all 0.
- R2: For a hit record (`rec_is_z`=0 when the event begins), the first output word is {8'hC0, lrb_err, 8'h00, event_num}. These fields are sampled in the cycle the event begins.
- R3: For a Z record (`rec_is_z`=1), the first output word is {8'hB0, lrb_err, 8'h00, event_num}.
- R4: In a hit record, each accepted payload word appears on the output unchanged, in the order it was accepted.
- R5: In a Z record, each payload word leaves with bits [31:29] = 3'b011, bits [28:26] = the `smt_id` sampled when the event began, and bits [25:0] unchanged.
- R6: The last word of a record is {4'b1111, s, m, l, n, 8'h00, count, event}. Bits 27..24 = {`err_smt`, `err_seq`, `err_lrb`, `err_evt`}, sampled in the cycle the end-of-event strobe is accepted.
- R7: The count field (bits [15:8]) equals the number of payload words in the record. It saturates at 255 and never wraps.
- R8: An event that has no payload words still produces a header and a trailer, with count 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change in the next cycle.
- R10: After a trailer is accepted, `out_valid` is 0 in the next cycle. No header of a new record is issued before the previous trailer has been accepted.
- R11: In a hit record, accepting a payload word with bits [31:26] = 0 sets `trk_err`. The flag stays set until the next record's header is loaded. Z records never set it.
- R12: When the end-of-event strobe arrives together with a payload word, that word is the last payload word and is included in the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | A payload word is offered |
| in_data | input | 32 | Payload word |
| in_eoe | input | 1 | End-of-event strobe, may accompany the last word |
| in_ready | output | 1 | Payload word and/or end-of-event strobe are accepted this cycle |
| rec_is_z | input | 1 | Record type: 0 for hit, 1 for Z; sampled when the event begins |
| event_num | input | 8 | Event number, sampled when the event begins |
| lrb_err | input | 8 | Link error byte placed in the header |
| smt_id | input | 3 | Source id inserted into Z payload words |
| err_smt | input | 1 | Data error flag for the trailer |
| err_seq | input | 1 | Sequencer id mismatch flag for the trailer |
| err_lrb | input | 1 | Link error flag for the trailer |
| err_evt | input | 1 | Event number mismatch flag for the trailer |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Output word is taken |
| trk_err | output | 1 | A hit payload word with track number 0 was seen in the current record |

## Verification
The end-of-event strobe can fall in the same cycle as the last payload word. In that cycle the word is loaded into the output register and the trailer flags are captured, so the count and the trailer both depend on the merged handshake. The bench provokes this collision on purpose in directed events, including one with a track-0 word, and at random in many other events. Random output stalls run throughout, so some of these collisions meet a stalled output register. Every emitted word is compared with an expected record computed from the stimulus. The count, the flags and `trk_err` are judged when each trailer is accepted.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int WORD_W = 32;
  localparam logic [7:0] HDR_HIT  = 8'hC0;
  localparam logic [7:0] HDR_Z    = 8'hB0;
  localparam logic [2:0] Z_TAG    = 3'b011;
  localparam logic [3:0] TRL_TAG  = 4'b1111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_TRL  = 2'd2,
    ST_WAIT = 2'd3
  } hrf_state_e;

  typedef enum logic [1:0] {
    K_HDR = 2'd0,
    K_PAY = 2'd1,
    K_TRL = 2'd2
  } hrf_kind_e;
endpackage

// File: rtl/hrf_word_fmt.sv
module hrf_word_fmt
  import hrf_pkg::*;
#(
  parameter int EVT_W = 8,
  parameter int CNT_W = 8,
  parameter int ID_W  = 3
) (
  input  hrf_kind_e          kind,
  input  logic               is_z,
  input  logic [EVT_W-1:0]   evt,
  input  logic [7:0]         lrb,
  input  logic [ID_W-1:0]    smt_id,
  input  logic [3:0]         flags,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [WORD_W-1:0]  pay,
  output logic [WORD_W-1:0]  word
);
  localparam int Z_LO = WORD_W - 3 - ID_W;

  logic [WORD_W-1:0] hdr_w, pay_w, trl_w;

  always_comb begin
    hdr_w = {(is_z ? HDR_Z : HDR_HIT), lrb, 8'h00, 8'(evt)};
    trl_w = {TRL_TAG, flags, 8'h00, 8'(cnt), 8'(evt)};
    if (is_z) pay_w = {Z_TAG, smt_id, pay[Z_LO-1:0]};
    else      pay_w = pay;
    case (kind)
      K_HDR:   word = hdr_w;
      K_PAY:   word = pay_w;
      default: word = trl_w;
    endcase
  end
endmodule

// File: rtl/hrf_event_stats.sv
module hrf_event_stats #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int TRK_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic              is_z,
  input  logic [DATA_W-1:0] word,
  output logic [CNT_W-1:0]  cnt,
  output logic              trk_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trk_q, trk_d;
  logic             trk_zero;

  assign trk_zero = (word[DATA_W-1 -: TRK_W] == '0);

  always_comb begin
    cnt_d = cnt_q;
    trk_d = trk_q;
    if (clr) begin
      cnt_d = '0;
      trk_d = 1'b0;
    end else if (inc) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (!is_z && trk_zero) trk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      trk_q <= 1'b0;
    end else if (clr || inc) begin
      cnt_q <= cnt_d;
      trk_q <= trk_d;
    end
  end

  assign cnt     = cnt_q;
  assign trk_err = trk_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

  assert_cnt_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !$isunknown(cnt_q)) |=> (cnt_q >= $past(cnt_q)));

  assert_trk_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !is_z && word[DATA_W-1 -: TRK_W] == '0) |=> trk_q);
endmodule

// File: rtl/hit_record_framer.sv
module hit_record_framer
  import hrf_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TRK_W = 6,
  parameter int EVT_W = 8,
  parameter int ID_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  input  logic              in_eoe,
  output logic              in_ready,
  input  logic              rec_is_z,
  input  logic [EVT_W-1:0]  event_num,
  input  logic [7:0]        lrb_err,
  input  logic [ID_W-1:0]   smt_id,
  input  logic              err_smt,
  input  logic              err_seq,
  input  logic              err_lrb,
  input  logic              err_evt,
  output logic              out_valid,
  output logic [31:0]       out_data,
  input  logic              out_ready,
  output logic              trk_err
);
  hrf_state_e state_q, state_d;

  logic              is_z_q;
  logic [EVT_W-1:0]  evt_q;
  logic [ID_W-1:0]   id_q;
  logic [3:0]        flags_q;
  logic [31:0]       out_q;
  logic              out_v_q, out_v_d;
  hrf_kind_e         kind_q, kind_sel;

  logic slot_free, hdr_ld, pay_acc, eoe_acc, trl_ld, out_ld, trl_done;
  logic              fmt_is_z;
  logic [EVT_W-1:0]  fmt_evt;
  logic [31:0]       fmt_word;
  logic [CNT_W-1:0]  cnt;

  // Handshake decode
  assign slot_free = !out_v_q || out_ready;
  assign in_ready  = (state_q == ST_BODY) && slot_free;
  assign pay_acc   = in_ready && in_valid;
  assign eoe_acc   = in_ready && in_eoe;
  assign hdr_ld    = (state_q == ST_IDLE) && !out_v_q && (in_valid || in_eoe);
  assign trl_ld    = (state_q == ST_TRL) && slot_free;
  assign trl_done  = (state_q == ST_WAIT) && out_v_q && out_ready;
  assign out_ld    = hdr_ld || pay_acc || trl_ld;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (hdr_ld)   state_d = ST_BODY;
      ST_BODY: if (eoe_acc)  state_d = ST_TRL;
      ST_TRL:  if (trl_ld)   state_d = ST_WAIT;
      default: if (trl_done) state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (hdr_ld)       kind_sel = K_HDR;
    else if (pay_acc) kind_sel = K_PAY;
    else              kind_sel = K_TRL;
    fmt_is_z = hdr_ld ? rec_is_z  : is_z_q;
    fmt_evt  = hdr_ld ? event_num : evt_q;
    out_v_d  = out_v_q;
    if (out_ld)         out_v_d = 1'b1;
    else if (out_ready) out_v_d = 1'b0;
  end

  hrf_word_fmt #(.EVT_W(EVT_W), .CNT_W(CNT_W), .ID_W(ID_W)) u_fmt (
    .kind   (kind_sel),
    .is_z   (fmt_is_z),
    .evt    (fmt_evt),
    .lrb    (lrb_err),
    .smt_id (id_q),
    .flags  (flags_q),
    .cnt    (cnt),
    .pay    (in_data),
    .word   (fmt_word)
  );

  hrf_event_stats #(.DATA_W(32), .CNT_W(CNT_W), .TRK_W(TRK_W)) u_stats (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hdr_ld),
    .inc     (pay_acc),
    .is_z    (is_z_q),
    .word    (in_data),
    .cnt     (cnt),
    .trk_err (trk_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_z_q <= 1'b0;
      evt_q  <= '0;
      id_q   <= '0;
    end else if (hdr_ld) begin
      is_z_q <= rec_is_z;
      evt_q  <= event_num;
      id_q   <= smt_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (eoe_acc) flags_q <= {err_smt, err_seq, err_lrb, err_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      kind_q <= K_HDR;
    end else if (out_ld) begin
      out_q  <= fmt_word;
      kind_q <= kind_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_v_q <= 1'b0;
    else        out_v_q <= out_v_d;
  end

  assign out_valid = out_v_q;
  assign out_data  = out_q;

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v_q && !out_ready) |=> (out_v_q && $stable(out_q)));

  assert_gap_after_trailer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v_q && out_ready && kind_q == K_TRL) |=> !out_v_q);

  assert_ztag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v_q && kind_q == K_PAY && is_z_q) |->
      (out_q[31:29] == 3'b011 && out_q[28:26] == id_q));

  assert_trailer_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v_q && kind_q == K_TRL) |-> (out_q[31:28] == 4'hF && out_q[23:16] == 8'h00));

  assert_no_accept_in_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && out_v_q) |-> !in_ready);
endmodule

// File: tb/hit_record_framer_tb.sv
module hit_record_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_eoe, in_ready;
  logic [31:0] in_data;
  logic        rec_is_z;
  logic [7:0]  event_num, lrb_err;
  logic [2:0]  smt_id;
  logic        err_smt, err_seq, err_lrb, err_evt;
  logic        out_valid, out_ready, trk_err;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  hit_record_framer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_eoe(in_eoe), .in_ready(in_ready), .rec_is_z(rec_is_z),
    .event_num(event_num), .lrb_err(lrb_err), .smt_id(smt_id),
    .err_smt(err_smt), .err_seq(err_seq), .err_lrb(err_lrb), .err_evt(err_evt),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .trk_err(trk_err)
  );

  typedef struct {
    logic v; logic e; logic [31:0] d;
    logic z; logic [7:0] evt; logic [7:0] lrb; logic [2:0] id; logic [3:0] fl;
  } stim_t;

  typedef struct {
    logic [31:0] d; logic trl; logic trk; string req;
  } exp_t;

  stim_t stim[$];
  exp_t  expq[$];
  int    n_chk = 0;
  int    n_err = 0;

  function automatic logic [31:0] exp_hdr(logic z, logic [7:0] lrb, logic [7:0] evt);
    return {(z ? 8'hB0 : 8'hC0), lrb, 8'h00, evt};
  endfunction

  function automatic logic [31:0] exp_pay(logic z, logic [2:0] id, logic [31:0] d);
    return z ? {3'b011, id, d[25:0]} : d;
  endfunction

  function automatic logic [31:0] exp_trl(logic [3:0] fl, int n, logic [7:0] evt);
    logic [7:0] c;
    c = (n > 255) ? 8'd255 : 8'(n);
    return {4'hF, fl, 8'h00, c, evt};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic add_event(input logic z, input logic [7:0] evt, input logic [7:0] lrb,
                           input logic [2:0] id, input logic [3:0] fl, input int n,
                           input logic merge, input logic trk0, input int gaps);
    stim_t s;
    exp_t  x;
    logic  any0 = 1'b0;
    s.z = z; s.evt = evt; s.lrb = lrb; s.id = id; s.fl = fl;
    x.d = exp_hdr(z, lrb, evt); x.trl = 1'b0; x.trk = 1'b0;
    x.req = z ? "R3 Z header" : "R2 hit header";
    expq.push_back(x);
    for (int i = 0; i < n; i++) begin
      s.d = $urandom;
      if (trk0 && i == n / 2) s.d[31:26] = 6'd0;
      if (!z && s.d[31:26] == 6'd0) any0 = 1'b1;
      s.v = 1'b1;
      s.e = merge && (i == n - 1);
      if (gaps > 0 && ($urandom % 4) == 0) begin
        stim_t g = s;
        g.v = 1'b0; g.e = 1'b0;
        stim.push_back(g);
      end
      stim.push_back(s);
      x.d = exp_pay(z, id, s.d);
      x.req = z ? "R5 Z payload" : "R4 hit payload";
      expq.push_back(x);
    end
    if (!(merge && n > 0)) begin
      s.v = 1'b0; s.e = 1'b1; s.d = $urandom;
      stim.push_back(s);
    end
    x.d = exp_trl(fl, n, evt); x.trl = 1'b1; x.trk = any0;
    if (n == 0)            x.req = "R8 empty trailer";
    else if (n > 255)      x.req = "R7 saturated trailer";
    else if (merge)        x.req = "R12 merged-eoe trailer";
    else                   x.req = "R6 trailer";
    expq.push_back(x);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int si = 0;
    logic prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic prev_trl_acc = 1'b0;
    exp_t x;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 0; in_eoe = 0; in_data = '0; rec_is_z = 0;
    event_num = '0; lrb_err = '0; smt_id = '0; out_ready = 0;
    {err_smt, err_seq, err_lrb, err_evt} = 4'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready && !trk_err, "R1 reset outputs",
          {29'd0, out_valid, in_ready, trk_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_ready && !trk_err, "R1 after release",
          {29'd0, out_valid, in_ready, trk_err}, 32'd0);

    // Directed corner cases
    add_event(1'b0, 8'h11, 8'hA5, 3'd2, 4'b1010, 0, 1'b0, 1'b0, 0);   // R8 hit
    add_event(1'b1, 8'h12, 8'h3C, 3'd5, 4'b0101, 0, 1'b0, 1'b0, 0);   // R8 Z
    add_event(1'b0, 8'h13, 8'h00, 3'd0, 4'b1111, 5, 1'b1, 1'b1, 0);   // R11 R12
    add_event(1'b1, 8'h14, 8'hFF, 3'd7, 4'b0001, 6, 1'b1, 1'b1, 1);   // R5, no R11
    add_event(1'b0, 8'h15, 8'h42, 3'd1, 4'b1000, 300, 1'b0, 1'b0, 0); // R7 saturation
    add_event(1'b0, 8'h16, 8'h42, 3'd1, 4'b0000, 1, 1'b1, 1'b0, 0);   // R12 single
    for (int k = 0; k < 40; k++)
      add_event(1'($urandom), 8'($urandom), 8'($urandom), 3'($urandom),
                4'($urandom), int'($urandom % 13), 1'($urandom), 1'($urandom % 5 == 0), 1);

    while (si < stim.size() || expq.size() > 0) begin
      @(negedge clk);
      out_ready = (($urandom % 4) != 0);
      if (si < stim.size()) begin
        in_valid = stim[si].v; in_eoe = stim[si].e; in_data = stim[si].d;
        rec_is_z = stim[si].z; event_num = stim[si].evt; lrb_err = stim[si].lrb;
        smt_id = stim[si].id;
        {err_smt, err_seq, err_lrb, err_evt} = stim[si].fl;
      end else begin
        in_valid = 1'b0; in_eoe = 1'b0;
      end
      #1;
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R9 stall hold", out_data, prev_data);
      if (prev_trl_acc)
        check(!out_valid, "R10 gap after trailer", {31'd0, out_valid}, 32'd0);
      prev_trl_acc = 1'b0;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10 unexpected word", out_data, 32'd0);
        end else begin
          x = expq.pop_front();
          check(out_data == x.d, x.req, out_data, x.d);
          if (x.trl) begin
            check(trk_err == x.trk, "R11 track error flag", {31'd0, trk_err}, {31'd0, x.trk});
            prev_trl_acc = 1'b1;
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (si < stim.size() && (in_ready || (!stim[si].v && !stim[si].e))) si++;
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule